// File: doc/BRIEF.md
# Glitch-Free Clock Freeze Gate

This block sits between a bank of free-running clocks and their output pins. It stops each output or lets it run, under a per-output run bit. A stopped output is parked at logic low. The gate changes state only while that output's own source clock is low. As a result, freezing or releasing an output never produces a shortened high or low phase.

Of the fourteen outputs, the upper two always pass their source through unchanged. These are one bank clock and the feedback clock, and they can never be stopped, so a bad enable vector cannot break the feedback loop. The lower twelve each take the run bit of the same index. A run bit of 1 lets the output run. A run bit of 0 freezes it.

Top module: `clk_frz_gate`

## Requirements
- R1: Outputs 12 and 13 follow their source clocks at all times, whatever the run vector holds. Output k for k in 0..11 is controlled by run bit k.
- R2: While the run value in force for output k is 0, that output stays at logic 0.
- R3: While the run value in force for output k is 1, that output equals its source clock.
- R4: A new run bit value comes into force at the next falling edge of that output's own source clock. Until then, the output keeps its previous behaviour, including for the rest of a high phase that is in progress.
- R5: Every rising edge of an output coincides with a rising edge of its source. Every high pulse on an output lasts exactly the source high time.
- R6: Every low interval on an output lasts at least the source low time.
- R7: While rst_ni is low, every output follows its source. After rst_ni rises, every output keeps running until the first falling edge of its source that is sampled with reset released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset; forces every run value to 1 |
| clk_src_i | input | 14 | Free-running source clocks, one per output |
| run_en_i | input | 12 | Run bits for outputs 0..11; 1 runs, 0 freezes |
| clk_o | output | 14 | Gated clocks |

## Verification
The hardest case to reach is a run bit that changes during a source high phase, or just before a falling edge. A correct gate must then finish the pulse in progress and must not cut it short. The bench drives fourteen sources with different high and low times. It changes the run vector at half-nanosecond offsets, with irregular hold times, so every phase relation between a run change and each source occurs many times. Monitors on every output measure each pulse and each gap, and compare them with the source timing.

// File: rtl/clk_frz_pkg.sv
`timescale 1ns/1ps
package clk_frz_pkg;
  parameter int unsigned CLK_N     = 14;
  parameter int unsigned CLK_FIXED = 2;
endpackage

// File: rtl/clk_frz_cell.sv
`timescale 1ns/1ps
module clk_frz_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic clk_o
);
  logic run_q;

  // Run bit moves only on the falling edge, so the AND below switches while clk_i is low.
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b1;
    else         run_q <= run_i;
  end

  assign clk_o = clk_i & run_q;

  a_r2_frozen_low: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !run_q |-> !clk_o)
    else $error("a_r2_frozen_low");

  a_r5_full_high: assert property (@(negedge clk_i) disable iff (!rst_ni)
    run_q |-> clk_o)
    else $error("a_r5_full_high");

  always @(run_q) begin
    if (rst_ni) a_r4_gate_change_low: assert (!clk_i) else $error("a_r4_gate_change_low");
  end

  always @(posedge clk_o) begin
    if (rst_ni) a_r5_rise_with_src: assert (clk_i) else $error("a_r5_rise_with_src");
  end

  always @(negedge clk_o) begin
    if (rst_ni) a_r6_fall_with_src: assert (!clk_i) else $error("a_r6_fall_with_src");
  end
endmodule

// File: rtl/clk_frz_pass.sv
`timescale 1ns/1ps
module clk_frz_pass (
  input  logic clk_i,
  output logic clk_o
);
  // Never gated: keeps the feedback path alive (R1).
  assign clk_o = clk_i;
endmodule

// File: rtl/clk_frz_gate.sv
`timescale 1ns/1ps
module clk_frz_gate #(
  parameter  int unsigned N_CLK   = clk_frz_pkg::CLK_N,
  parameter  int unsigned N_FIXED = clk_frz_pkg::CLK_FIXED,
  localparam int unsigned N_GATED = N_CLK - N_FIXED
) (
  input  logic               rst_ni,
  input  logic [N_CLK-1:0]   clk_src_i,
  input  logic [N_GATED-1:0] run_en_i,
  output logic [N_CLK-1:0]   clk_o
);
  for (genvar k = 0; k < N_CLK; k++) begin : g_out
    if (k < N_GATED) begin : g_gated
      clk_frz_cell u_cell (
        .clk_i  (clk_src_i[k]),
        .rst_ni (rst_ni),
        .run_i  (run_en_i[k]),
        .clk_o  (clk_o[k])
      );
    end else begin : g_fixed
      clk_frz_pass u_pass (
        .clk_i (clk_src_i[k]),
        .clk_o (clk_o[k])
      );
    end
  end

  for (genvar k = N_GATED; k < N_CLK; k++) begin : g_chk_fixed
    always @(clk_src_i[k] or clk_o[k]) begin
      #0 a_r1_fixed_follow: assert (clk_o[k] == clk_src_i[k]) else $error("a_r1_fixed_follow");
    end
  end
endmodule

// File: tb/sim_clk_frz_gate.sv
`timescale 1ns/1ps
module sim_clk_frz_gate;
  localparam real TCK = 10.0;
  localparam int  NC  = 14;
  localparam int  NG  = 12;

  logic          rst_ni;
  logic [NG-1:0] run_en;
  wire  [NC-1:0] src;
  wire  [NC-1:0] y;
  int n_chk = 0, n_bad = 0;
  bit chk_on = 0, done = 0;

  function automatic real hi_t(int k); return TCK/2 + (k % 3); endfunction
  function automatic real lo_t(int k); return TCK/2 + (k % 4); endfunction
  function automatic bit near(real a, real b); return (a - b < 0.001) && (b - a < 0.001); endfunction

  task automatic check(bit ok, string msg);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s", msg);
    end
  endtask

  clk_frz_gate u0 (.rst_ni(rst_ni), .clk_src_i(src), .run_en_i(run_en), .clk_o(y));

  for (genvar k = 0; k < NC; k++) begin : g_mon
    logic s = 1'b0;
    logic m = 1'b1;
    real  t_src_rise = 0.0, t_y_rise = 0.0, t_y_fall = 0.0;
    bit   seen_rise = 0, seen_fall = 0;
    assign src[k] = s;

    initial forever begin
      #(lo_t(k)); s = 1'b1;
      #(hi_t(k)); s = 1'b0;
    end

    // Expected run value in force: R4 (falling-edge capture), R7 (reset forces run), R1 (fixed outputs).
    if (k < NG) begin : g_mod
      always @(negedge s or negedge rst_ni)
        if (!rst_ni) m <= 1'b1;
        else         m <= run_en[k];
    end

    always @(posedge s) t_src_rise = $realtime;

    // Level check mid-high phase: R1/R2/R3/R7.
    always @(posedge s) begin
      #(hi_t(k)/2);
      if (chk_on)
        check(y[k] === m, $sformatf("%s out=%0d act=%b exp=%b",
              (!rst_ni) ? "R7" : (k >= NG) ? "R1" : m ? "R3" : "R2", k, y[k], m));
    end

    // Edge checks: R5 rise alignment and full high, R6 minimum low.
    always @(posedge y[k]) begin
      #0.01;
      if (chk_on) begin
        check(near($realtime - 0.01, t_src_rise),
              $sformatf("R5 rise out=%0d act=%0.3f exp=%0.3f", k, $realtime - 0.01, t_src_rise));
        if (seen_fall)
          check(($realtime - 0.01 - t_y_fall) > lo_t(k) - 0.001,
                $sformatf("R6 low out=%0d act=%0.3f exp>=%0.3f", k, $realtime - 0.01 - t_y_fall, lo_t(k)));
      end
      t_y_rise = $realtime - 0.01;
      seen_rise = 1;
    end

    always @(negedge y[k]) begin
      #0.01;
      if (chk_on && seen_rise)
        check(near($realtime - 0.01 - t_y_rise, hi_t(k)),
              $sformatf("R5 high out=%0d act=%0.3f exp=%0.3f", k, $realtime - 0.01 - t_y_rise, hi_t(k)));
      t_y_fall = $realtime - 0.01;
      seen_fall = 1;
    end
  end

  initial begin
    logic [15:0] lfsr;
    rst_ni = 1'b1;
    run_en = '0;
    #1 rst_ni = 1'b0;
    chk_on = 1;
    #(6*TCK + 0.5);            // R7: run bits 0 during reset, outputs must still run
    rst_ni = 1'b1;
    #(4*TCK);                  // R7: still running after release until vector is sampled
    run_en = '1;  #40;
    run_en = '0;  #60;         // R2: everything gated freezes
    run_en = '1;  #37;
    for (int i = 0; i < NG; i++) begin
      run_en = ~(12'(1) << i); #23;
    end
    for (int i = 0; i < NG; i++) begin
      run_en = 12'(1) << i;    #29;
    end
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      run_en = lfsr[11:0];
      #(3 + (lfsr % 19));      // R4: changes land in every phase of every source
    end
    run_en = '1;
    #(5*TCK);
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20000*TCK);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule